// File: doc/BRIEF.md
# Message Schedule Word Generator

This unit supplies the per-round message word to a 256-bit hash round datapath. A block is delivered as sixteen 32-bit words on a 32-bit bus. In the first sixteen rounds each word is passed straight through to the output. In the later rounds the unit computes a new word from the words it has already stored. It uses a window of only sixteen registers, and this window moves by one position on each round.

A round is taken on every clock edge where `stepEn` is high. A one-cycle `blockStart` pulse returns the round index to zero. When it arrives together with a step, that step counts as round 0 of the new block, so words from an earlier block (finished or abandoned) never leak into the new one. The output word depends combinationally on the current index, the window and the input bus. The round datapath reads it in the same cycle that it takes the step.

Top module: `msg_schedule`

## Requirements
- R1: After reset `roundIdx` is 0. While the index is below 16, `wOut` equals `wordIn`.
- R2: In rounds 0 to 15, `wOut` equals `wordIn` in the same cycle, and the step stores that word in the window.
- R3: In rounds 16 to 63, `wOut` = W[t-16] + s0(W[t-15]) + W[t-7] + s1(W[t-2]) modulo 2^32, where W[k] is the word output in round k of the same block. `wordIn` has no effect on `wOut` in these rounds.
- R4: s0(x) is the XOR of x rotated right by 7, x rotated right by 18, and x logically shifted right by 3.
- R5: s1(x) is the XOR of x rotated right by 17, x rotated right by 19, and x logically shifted right by 10.
- R6: In a cycle with `stepEn` low, the window does not move. If `blockStart` is also low, `roundIdx` and `wOut` keep their values for rounds 16 to 63.
- R7: Each step moves `roundIdx` up by one. After the step in round 63 it reads 0.
- R8: `blockStart` forces `roundIdx` to 0 in the cycle where it is high. Together with `stepEn`, that step is round 0. Without `stepEn`, the index stays 0 in the next cycle. A block that starts part way through another block produces the full correct 64-word schedule of the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| blockStart | input | 1 | Starts a new block; the index is 0 in this cycle |
| stepEn | input | 1 | Takes one round at the next clock edge |
| wordIn | input | 32 | Message word for rounds 0 to 15 |
| roundIdx | output | 6 | Index of the current round |
| wOut | output | 32 | Message word for the current round |

## Verification
On every cycle, the assertions check how the index moves: increment, wrap, hold, and restart. They also check that the window's tail takes exactly the word that was output, that the window stays frozen without a step, and that the input passes through during the load rounds. Only the bench's scenarios can show that the expanded words equal the arithmetic recurrence with both sigma functions. The same holds for correct results after stalls, and for a second block being clean after an abandoned one. For these checks the bench compares all 64 words of several blocks against its own reference model.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic shiftEn;
    logic selLoad;
  } schedCtrl_t;

  function automatic logic [WORD_W-1:0] smallSigma0(input logic [WORD_W-1:0] x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] smallSigma1(input logic [WORD_W-1:0] x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x >> 10);
  endfunction

endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int ROUNDS     = 64,
  parameter int LOAD_WORDS = 16,
  localparam int IDX_W     = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blockStart,
  input  logic             stepEn,
  output schedCtrl_t       ctrl,
  output logic [IDX_W-1:0] curIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    curIdx       = blockStart ? '0 : idxQ;
    idxNext      = (curIdx == LAST_IDX) ? '0 : curIdx + ONE_IDX;
    ctrl.shiftEn = stepEn;
    ctrl.selLoad = (int'(curIdx) < LOAD_WORDS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       idxQ <= '0;
    else if (stepEn) idxQ <= idxNext;
    else if (blockStart) idxQ <= '0;
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && curIdx != LAST_IDX) |=> idxQ == $past(curIdx) + ONE_IDX); // R7
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && curIdx == LAST_IDX) |=> idxQ == '0); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !blockStart) |=> $stable(idxQ)); // R6
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && !stepEn) |=> idxQ == '0); // R8

endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int LOAD_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedCtrl_t        ctrl,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] wCur
);

  localparam int TAP_M16 = 0;
  localparam int TAP_M15 = 1;
  localparam int TAP_M7  = LOAD_WORDS - 7;
  localparam int TAP_M2  = LOAD_WORDS - 2;
  localparam int TAIL    = LOAD_WORDS - 1;

  logic [WORD_W-1:0] win [LOAD_WORDS];
  logic [WORD_W-1:0] expanded;

  always_comb begin
    expanded = win[TAP_M16] + smallSigma0(win[TAP_M15])
             + win[TAP_M7]  + smallSigma1(win[TAP_M2]);
    wCur     = ctrl.selLoad ? wordIn : expanded;
  end

  for (genvar i = 0; i < LOAD_WORDS; i++) begin : g_stage
    if (i == TAIL) begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             win[i] <= '0;
        else if (ctrl.shiftEn) win[i] <= wCur;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             win[i] <= '0;
        else if (ctrl.shiftEn) win[i] <= win[i+1];
      end
    end
  end

  AST_TAIL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> win[TAIL] == $past(wCur)); // R2
  AST_OLDEST_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> win[TAP_M16] == $past(win[TAP_M15])); // R3
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> ($stable(win[TAP_M16]) && $stable(win[TAIL]))); // R6

endmodule

// File: rtl/msg_schedule.sv
module msg_schedule
  import sched_pkg::*;
#(
  parameter int ROUNDS     = 64,
  parameter int LOAD_WORDS = 16,
  localparam int IDX_W     = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blockStart,
  input  logic             stepEn,
  input  logic [31:0]      wordIn,
  output logic [IDX_W-1:0] roundIdx,
  output logic [31:0]      wOut
);

  schedCtrl_t ctrl;

  sched_ctrl #(
    .ROUNDS     (ROUNDS),
    .LOAD_WORDS (LOAD_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .blockStart (blockStart),
    .stepEn     (stepEn),
    .ctrl       (ctrl),
    .curIdx     (roundIdx)
  );

  sched_datapath #(
    .LOAD_WORDS (LOAD_WORDS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wordIn (wordIn),
    .wCur   (wOut)
  );

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (int'(roundIdx) < LOAD_WORDS) |-> wOut == wordIn); // R2
  AST_START_IDX: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> roundIdx == '0); // R8

endmodule

// File: tb/tb_msg_schedule.sv
module tb_msg_schedule;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blockStart = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] wordIn = '0;
  logic [5:0]  roundIdx;
  logic [31:0] wOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] msgBuf [16];
  logic [31:0] refW [64];

  always #5 clk = ~clk;

  msg_schedule dut (
    .clk(clk), .rstN(rstN), .blockStart(blockStart), .stepEn(stepEn),
    .wordIn(wordIn), .roundIdx(roundIdx), .wOut(wOut)
  );

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] sg0(input logic [31:0] x); // R4
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sg1(input logic [31:0] x); // R5
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction

  task automatic computeRef();
    for (int t = 0; t < 64; t++) begin
      if (t < 16) refW[t] = msgBuf[t];
      else refW[t] = refW[t-16] + sg0(refW[t-15]) + refW[t-7] + sg1(refW[t-2]);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // runs rounds 0..nRounds-1; stallEvery>0 inserts an idle cycle after every such round
  task automatic runBlock(input bit useStart, input int nRounds, input int stallEvery);
    computeRef();
    for (int t = 0; t < nRounds; t++) begin
      @(negedge clk);
      blockStart = useStart && (t == 0);
      stepEn = 1'b1;
      wordIn = (t < 16) ? msgBuf[t] : $urandom;
      #2;
      chk("R7 index", {26'd0, roundIdx}, t);
      if (t < 16) chk("R2 load word", wOut, msgBuf[t]);
      else chk("R3 expanded word", wOut, refW[t]);
      if (stallEvery > 0 && (t % stallEvery) == stallEvery - 1) begin
        @(negedge clk);
        blockStart = 1'b0;
        stepEn = 1'b0;
        wordIn = $urandom;
        #2;
        chk("R6 index hold", {26'd0, roundIdx}, t + 1);
        if (t + 1 < 16) chk("R6 load pass in stall", wOut, wordIn);
        else if (t + 1 < 64) chk("R6 word hold", wOut, refW[t+1]);
      end
    end
    @(negedge clk);
    blockStart = 1'b0;
    stepEn = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wordIn = 32'hA5A5_1234;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1 reset index", {26'd0, roundIdx}, 0);
    chk("R1 reset pass", wOut, 32'hA5A5_1234);

    // all-zero block
    for (int i = 0; i < 16; i++) msgBuf[i] = '0;
    runBlock(1'b1, 64, 0);
    #2;
    chk("R7 wrap to zero", {26'd0, roundIdx}, 0);

    // padded three-byte message
    for (int i = 0; i < 16; i++) msgBuf[i] = '0;
    msgBuf[0] = 32'h6162_6380;
    msgBuf[15] = 32'h0000_0018;
    runBlock(1'b1, 64, 0);

    // single-bit patterns exercise each rotate and shift (R4, R5)
    for (int b = 0; b < 32; b += 5) begin
      for (int i = 0; i < 16; i++) msgBuf[i] = 32'h1 << ((b + i) % 32);
      runBlock(1'b1, 64, 0);
    end

    // incrementing words with stalls
    for (int i = 0; i < 16; i++) msgBuf[i] = 32'h0101_0101 * (i + 1);
    runBlock(1'b1, 64, 3);

    // abandoned block then a fresh block started together with a step (R8)
    for (int i = 0; i < 16; i++) msgBuf[i] = $urandom;
    runBlock(1'b1, 23, 0);
    for (int i = 0; i < 16; i++) msgBuf[i] = $urandom;
    runBlock(1'b1, 64, 0);

    // abandoned block, then a start pulse alone, then a block without start (R8)
    for (int i = 0; i < 16; i++) msgBuf[i] = ~(32'h0 + i);
    runBlock(1'b1, 40, 0);
    @(negedge clk);
    blockStart = 1'b1;
    stepEn = 1'b0;
    #2;
    chk("R8 start index", {26'd0, roundIdx}, 0);
    @(negedge clk);
    blockStart = 1'b0;
    #2;
    chk("R8 index after lone start", {26'd0, roundIdx}, 0);
    for (int i = 0; i < 16; i++) msgBuf[i] = $urandom;
    runBlock(1'b0, 64, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule